// File: doc/BRIEF.md
# Synchronous Burst SRAM

This block is a synthesizable behavioural model of a small synchronous static RAM with a built-in burst address sequencer. Each word is made of byte lanes of nine bits: eight data bits and one parity bit, stored as given. Address, chip select, burst controls and write controls are all sampled on the rising clock edge. Write data follows one cycle behind its command. It is parked in a one-entry late-write buffer, and a bypass lets a read that comes right after the write see the new value.

Two static mode pins shape the read side. `pipe_sel` chooses between a flow-through read path (data in the cycle after the command edge) and a registered path (one cycle later). `dual_desel` chooses how long the data drivers stay on after the last read. In single-deselect mode they turn off as soon as no read data is due. In dual-deselect mode they stay on for one extra cycle, holding the last word. The mode pins, and `burst_lin`, may only change while no command is in flight.

Read data leaves on `rdata` qualified by `rvalid`. The stream has no back-pressure: every beat is shown for exactly one cycle, and the consumer must take it. The output enable `oe` and the sleep input act on the outputs without waiting for a clock. While asleep, commands are ignored and the contents are kept.

Top module: `sram_sync_burst`

## Requirements
- R1: With `pipe_sel`=0, a read command captured at edge k puts the word on `rdata`, with `rvalid`=1, in the cycle that follows edge k.
- R2: With `pipe_sel`=1, a read captured at edge k gives `rvalid`=0 after edge k, and the word with `rvalid`=1 after edge k+1.
- R3: With `dual_desel`=0, `dq_oe` is low in the cycle after the last read-data cycle when no further read follows.
- R4: With `dual_desel`=1, after the last read-data cycle, `dq_oe` stays high for one more cycle showing the same word with `rvalid`=0, and is low in the cycle after that.
- R5: A command with `bw_en`=1 and `glb_wr`=0 writes only those lanes whose `lane_wr` bit is set. Bit l controls `rdata`/`wdata` bits [9l+8:9l]. Strobes without `bw_en` or `glb_wr` make the command a read, and nothing is written.
- R6: `glb_wr`=1 writes every lane, whatever `bw_en` and `lane_wr` hold.
- R7: Write data is sampled on `wdata` at the edge after the write command. A read of the same address captured on that same edge returns the new data, in both read modes.
- R8: `oe`=0 forces `dq_oe`=0, `rvalid`=0 and `rdata`=0 at once, without a clock edge. Raising it again restores the pending output in the same cycle.
- R9: `sleep`=1 forces `dq_oe`=0 and `rvalid`=0 at once and keeps memory contents. Commands at edges where `sleep` is high are ignored. After `sleep` falls, the first edge is also ignored, and the second edge accepts a command.
- R10: `cs`=1, `load`=1 starts a burst at `addr`. Each later `cs`=1, `load`=0, `adv`=1 edge steps an index n by one, modulo 4. The low two address bits become (base+n) mod 4 when `burst_lin`=1 at the load, and base XOR n when it was 0. The upper bits are kept, and the fifth beat wraps to the start.
- R11: During and right after reset, `dq_oe`, `rvalid` and `rdata` are all zero.
- R12: `rvalid` is never high while `dq_oe` is low.
- R13: `bw_en`=1 with no `lane_wr` bit set is a write cycle that changes no lane and produces no read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pipe_sel | input | 1 | 1: registered read path, 0: flow-through |
| dual_desel | input | 1 | 1: drivers held one extra cycle after reads |
| burst_lin | input | 1 | Burst order captured at load: 1 linear, 0 interleaved |
| sleep | input | 1 | Low-power request; outputs off, commands ignored |
| oe | input | 1 | Asynchronous output enable, active high |
| cs | input | 1 | Chip select; low is a deselect |
| load | input | 1 | Load a new burst start address |
| adv | input | 1 | Step to the next address of an open burst |
| addr | input | ADDR_W (4) | Start address |
| glb_wr | input | 1 | Write all lanes |
| bw_en | input | 1 | Enable per-lane writes |
| lane_wr | input | LANES (2) | Per-lane write strobes |
| wdata | input | 18 | Write data, sampled one edge after the command |
| rdata | output | 18 | Read data, zero when not driven |
| rvalid | output | 1 | Fresh read data on `rdata` this cycle |
| dq_oe | output | 1 | Data drivers enabled |

## Verification
The hardest case to reach is a read that lands while the late-write buffer still holds the only copy of the word. At that point memory is stale and only the bypass can give the right answer. The bench gets there by placing a read command of the same address on the very edge that samples the write data. It does this in both read modes, so the registered path also captures through the bypass. A second hard spot is the one ignored edge after sleep ends. The bench puts a write command on that edge and a read on the next, so an early wake shows up as the new value returned through the bypass.

// File: rtl/sram_burst_pkg.sv
package sram_burst_pkg;
  // Operation held in the command stage after an accepted edge.
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;
endpackage

// File: rtl/sram_burst_seq.sv
module sram_burst_seq #(
  parameter int ADDR_W  = 4,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              step,
  input  logic              close,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic              lin_ord,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              open
);
  logic [ADDR_W-1:0]  base;
  logic [BURST_W-1:0] idx;
  logic [BURST_W-1:0] idx_nxt;
  logic [BURST_W-1:0] low;
  logic               lin_r;

  assign idx_nxt = idx + 1'b1;
  assign low     = lin_r ? (base[BURST_W-1:0] + idx_nxt) : (base[BURST_W-1:0] ^ idx_nxt);

  generate
    if (ADDR_W > BURST_W) begin : g_hi
      assign cur_addr = take ? ld_addr : {base[ADDR_W-1:BURST_W], low};
    end else begin : g_lo
      assign cur_addr = take ? ld_addr : low[ADDR_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base  <= '0;
      idx   <= '0;
      lin_r <= 1'b0;
      open  <= 1'b0;
    end else if (take) begin
      base  <= ld_addr;
      idx   <= '0;
      lin_r <= lin_ord;
      open  <= 1'b1;
    end else begin
      if (step)  idx  <= idx_nxt;
      if (close) open <= 1'b0;
    end
  end
endmodule

// File: rtl/sram_store.sv
module sram_store #(
  parameter int ADDR_W = 4,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cap,
  input  logic [ADDR_W-1:0]        cap_addr,
  input  logic [LANES-1:0]         cap_lanes,
  input  logic [LANE_W*LANES-1:0]  wdata,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [LANE_W*LANES-1:0]  rd_word
);
  localparam int DW    = LANE_W * LANES;
  localparam int DEPTH = 1 << ADDR_W;

  logic [DW-1:0]     mem [DEPTH];
  logic              pend_v;
  logic [ADDR_W-1:0] pend_addr;
  logic [LANES-1:0]  pend_lanes;
  logic [DW-1:0]     pend_data;

  // Late-write buffer: filled one edge after the command, retired on the next.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v     <= 1'b0;
      pend_addr  <= '0;
      pend_lanes <= '0;
      pend_data  <= '0;
    end else begin
      pend_v <= cap;
      if (cap) begin
        pend_addr  <= cap_addr;
        pend_lanes <= cap_lanes;
        pend_data  <= wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (pend_v) begin
      for (int l = 0; l < LANES; l++) begin
        if (pend_lanes[l]) mem[pend_addr][l*LANE_W +: LANE_W] <= pend_data[l*LANE_W +: LANE_W];
      end
    end
  end

  // Read with bypass from the buffer, lane by lane.
  always_comb begin
    rd_word = mem[rd_addr];
    if (pend_v && (pend_addr == rd_addr)) begin
      for (int l = 0; l < LANES; l++) begin
        if (pend_lanes[l]) rd_word[l*LANE_W +: LANE_W] = pend_data[l*LANE_W +: LANE_W];
      end
    end
  end
endmodule

// File: rtl/sram_rdpath.sv
module sram_rdpath #(
  parameter int DW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_now,
  input  logic [DW-1:0] word,
  input  logic          pipe_sel,
  input  logic          dual_sel,
  input  logic          oe,
  input  logic          sleep,
  output logic [DW-1:0] dout,
  output logic          dvalid,
  output logic          drive,
  output logic          stage_rd
);
  logic [DW-1:0] hold_q;
  logic          q_rd;
  logic          lag_rd;
  logic [DW-1:0] live;
  logic          on;

  assign stage_rd = pipe_sel ? q_rd : rd_now;
  assign live     = pipe_sel ? hold_q : (rd_now ? word : hold_q);
  assign on       = stage_rd | (dual_sel & lag_rd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      q_rd   <= 1'b0;
      lag_rd <= 1'b0;
    end else begin
      if (rd_now) hold_q <= word;
      q_rd   <= rd_now;
      lag_rd <= stage_rd;
    end
  end

  assign drive  = on & oe & ~sleep;
  assign dvalid = stage_rd & oe & ~sleep;
  assign dout   = drive ? live : '0;
endmodule

// File: rtl/sram_sync_burst.sv
module sram_sync_burst
  import sram_burst_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int LANE_W  = 9,
  parameter int LANES   = 2,
  parameter int BURST_W = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pipe_sel,
  input  logic                    dual_desel,
  input  logic                    burst_lin,
  input  logic                    sleep,
  input  logic                    oe,
  input  logic                    cs,
  input  logic                    load,
  input  logic                    adv,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    glb_wr,
  input  logic                    bw_en,
  input  logic [LANES-1:0]        lane_wr,
  input  logic [LANE_W*LANES-1:0] wdata,
  output logic [LANE_W*LANES-1:0] rdata,
  output logic                    rvalid,
  output logic                    dq_oe
);
  localparam int DW = LANE_W * LANES;

  logic              sleep_q;
  logic              awake;
  logic              go_ld;
  logic              go_adv;
  logic              close;
  logic              burst_open;
  logic              is_wr;
  logic [ADDR_W-1:0] seq_addr;
  logic [LANES-1:0]  lanes_in;
  op_e               s1_op;
  logic [ADDR_W-1:0] s1_addr;
  logic [LANES-1:0]  s1_lanes;
  logic              s1_rd;
  logic              s1_wr;
  logic              s1_busy;
  logic              stage_rd;
  logic [DW-1:0]     rd_word;

  // A command is taken only when sleep is low now and was low one edge ago.
  assign awake    = ~sleep & ~sleep_q;
  assign go_ld    = awake & cs & load;
  assign go_adv   = awake & cs & ~load & adv & burst_open;
  assign close    = awake & ~cs;
  assign is_wr    = glb_wr | bw_en;
  assign lanes_in = glb_wr ? {LANES{1'b1}} : (bw_en ? lane_wr : '0);

  sram_burst_seq #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (go_ld),
    .step    (go_adv),
    .close   (close),
    .ld_addr (addr),
    .lin_ord (burst_lin),
    .cur_addr(seq_addr),
    .open    (burst_open)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sleep_q  <= 1'b0;
      s1_op    <= OP_NONE;
      s1_addr  <= '0;
      s1_lanes <= '0;
    end else begin
      sleep_q <= sleep;
      if (go_ld || go_adv) begin
        s1_op    <= is_wr ? OP_WR : OP_RD;
        s1_addr  <= seq_addr;
        s1_lanes <= lanes_in;
      end else begin
        s1_op <= OP_NONE;
      end
    end
  end

  assign s1_rd   = (s1_op == OP_RD);
  assign s1_wr   = (s1_op == OP_WR);
  assign s1_busy = (s1_op != OP_NONE);

  sram_store #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap      (s1_wr),
    .cap_addr (s1_addr),
    .cap_lanes(s1_lanes),
    .wdata    (wdata),
    .rd_addr  (s1_addr),
    .rd_word  (rd_word)
  );

  sram_rdpath #(.DW(DW)) u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_now  (s1_rd),
    .word    (rd_word),
    .pipe_sel(pipe_sel),
    .dual_sel(dual_desel),
    .oe      (oe),
    .sleep   (sleep),
    .dout    (rdata),
    .dvalid  (rvalid),
    .drive   (dq_oe),
    .stage_rd(stage_rd)
  );
endmodule

// File: rtl/sram_sync_burst_chk.sv
module sram_sync_burst_chk (
  input logic clk,
  input logic rst_n,
  input logic pipe_sel,
  input logic dual_desel,
  input logic sleep,
  input logic oe,
  input logic cs,
  input logic load,
  input logic glb_wr,
  input logic bw_en,
  input logic rvalid,
  input logic dq_oe,
  input logic rdata_nz,
  input logic stage_rd,
  input logic s1_busy
);
  logic rd_take;
  assign rd_take = cs & load & ~glb_wr & ~bw_en & ~sleep & oe;

  p_flow_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_sel && rd_take && !$past(sleep)) |=> (rvalid || !oe || sleep));

  p_reg_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_sel && rd_take && !$past(sleep)) |=> ##1 (rvalid || !oe || sleep));

  p_scd_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!dual_desel && !stage_rd) |-> !dq_oe);

  p_dcd_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dual_desel && $fell(stage_rd) && oe && !sleep) |-> (dq_oe && !rvalid));

  p_oe_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> (!dq_oe && !rvalid && !rdata_nz));

  p_sleep_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> (!dq_oe && !rvalid));

  p_sleep_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> !s1_busy);

  p_wake_skip_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleep) |=> !s1_busy);

  p_valid_driven_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> dq_oe);
endmodule

bind sram_sync_burst sram_sync_burst_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pipe_sel  (pipe_sel),
  .dual_desel(dual_desel),
  .sleep     (sleep),
  .oe        (oe),
  .cs        (cs),
  .load      (load),
  .glb_wr    (glb_wr),
  .bw_en     (bw_en),
  .rvalid    (rvalid),
  .dq_oe     (dq_oe),
  .rdata_nz  (|rdata),
  .stage_rd  (stage_rd),
  .s1_busy   (s1_busy)
);

// File: tb/sram_sync_burst_test.sv
module sram_sync_burst_test;
  localparam int DW = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pipe_sel = 1'b0, dual_desel = 1'b0, burst_lin = 1'b1, sleep = 1'b0, oe = 1'b1;
  logic cs = 1'b0, load = 1'b0, adv = 1'b0, glb_wr = 1'b0, bw_en = 1'b0;
  logic [3:0] addr = '0;
  logic [1:0] lane_wr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic rvalid, dq_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [DW-1:0] model_mem [16];

  // Table: addr[25:22] glb[21] bw_en[20] lanes[19:18] data[17:0]
  localparam logic [25:0] TBL [8] = '{
    {4'd3,  1'b0, 1'b1, 2'b01, 18'h2A5C3},  // R5 lane 0 only
    {4'd3,  1'b0, 1'b1, 2'b10, 18'h15A3C},  // R5 lane 1 only
    {4'd8,  1'b0, 1'b1, 2'b11, 18'h3F00F},  // R5 both lanes
    {4'd8,  1'b0, 1'b1, 2'b00, 18'h00000},  // R13 enable, no strobes
    {4'd11, 1'b1, 1'b0, 2'b00, 18'h12345},  // R6 global alone
    {4'd12, 1'b1, 1'b1, 2'b01, 18'h2FEDC},  // R6 global overrides lanes
    {4'd13, 1'b0, 1'b0, 2'b11, 18'h3AAAA},  // R5 strobes without enable
    {4'd14, 1'b0, 1'b1, 2'b01, 18'h05555}
  };

  sram_sync_burst uut (
    .clk(clk), .rst_n(rst_n), .pipe_sel(pipe_sel), .dual_desel(dual_desel),
    .burst_lin(burst_lin), .sleep(sleep), .oe(oe), .cs(cs), .load(load), .adv(adv),
    .addr(addr), .glb_wr(glb_wr), .bw_en(bw_en), .lane_wr(lane_wr), .wdata(wdata),
    .rdata(rdata), .rvalid(rvalid), .dq_oe(dq_oe)
  );

  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic idle_in();
    cs = 1'b0; load = 1'b0; adv = 1'b0; glb_wr = 1'b0; bw_en = 1'b0; lane_wr = '0;
  endtask

  task automatic model_wr(input logic [3:0] a, input logic g, input logic b,
                          input logic [1:0] ln, input logic [DW-1:0] d);
    for (int l = 0; l < 2; l++)
      if (g || (b && ln[l])) model_mem[a][l*9 +: 9] = d[l*9 +: 9];
  endtask

  task automatic wr(input logic [3:0] a, input logic g, input logic b,
                    input logic [1:0] ln, input logic [DW-1:0] d);
    cs = 1'b1; load = 1'b1; adv = 1'b0; addr = a; glb_wr = g; bw_en = b; lane_wr = ln;
    tick();
    idle_in();
    wdata = d;
    tick();
    model_wr(a, g, b, ln, d);
  endtask

  task automatic rd(input logic [3:0] a, input string tag);
    cs = 1'b1; load = 1'b1; adv = 1'b0; addr = a; glb_wr = 1'b0; bw_en = 1'b0; lane_wr = '0;
    tick();
    idle_in();
    if (pipe_sel) tick();
    chk({tag, " data"}, 32'(rdata), 32'(model_mem[a]));
    chk({tag, " valid"}, 32'(rvalid), 32'd1);
    chk("R12 drivers on with valid", 32'(dq_oe), 32'd1);
    tick();
    tick();
  endtask

  initial begin
    #(8 * 30000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R11: reset state
    repeat (3) tick();
    chk("R11 reset dq_oe", 32'(dq_oe), 32'd0);
    chk("R11 reset rvalid", 32'(rvalid), 32'd0);
    chk("R11 reset rdata", 32'(rdata), 32'd0);
    rst_n = 1'b1;
    tick();
    chk("R11 after reset dq_oe", 32'(dq_oe), 32'd0);

    // Preload every word with a global write.
    for (int i = 0; i < 16; i++) wr(4'(i), 1'b1, 1'b0, 2'b00, 18'(i * 4099 + 7));

    // Table walk: writes, then readback in both read modes.
    for (int i = 0; i < 8; i++) begin
      logic [25:0] v;
      v = TBL[i];
      wr(v[25:22], v[21], v[20], v[19:18], v[17:0]);
    end
    for (int i = 0; i < 8; i++) rd(TBL[i][25:22], "R5 R6 R13 R1 flow readback");
    pipe_sel = 1'b1;
    for (int i = 0; i < 8; i++) rd(TBL[i][25:22], "R5 R6 R13 R2 registered readback");

    // R2: registered latency, nothing after the first edge.
    cs = 1'b1; load = 1'b1; addr = 4'd6;
    tick();
    idle_in();
    chk("R2 no data after first edge", 32'(rvalid), 32'd0);
    tick();
    chk("R2 data after second edge", 32'(rdata), 32'(model_mem[6]));
    chk("R2 valid after second edge", 32'(rvalid), 32'd1);
    tick(); tick();

    // R7: read on the edge that samples write data, both modes.
    for (int p = 0; p < 2; p++) begin
      logic [DW-1:0] d;
      pipe_sel = p[0];
      d = 18'h1B0D0 ^ 18'(p);
      cs = 1'b1; load = 1'b1; addr = 4'd9; glb_wr = 1'b1;
      tick();
      glb_wr = 1'b0; wdata = d;
      tick();
      idle_in();
      model_wr(4'd9, 1'b1, 1'b0, 2'b00, d);
      if (p == 1) tick();
      chk("R7 bypass data", 32'(rdata), 32'(d));
      chk("R7 bypass valid", 32'(rvalid), 32'd1);
      tick(); tick();
    end

    // R3 / R4: driver turn-off for each mode pair.
    for (int p = 0; p < 2; p++) begin
      for (int s = 0; s < 2; s++) begin
        pipe_sel = p[0]; dual_desel = s[0];
        cs = 1'b1; load = 1'b1; addr = 4'd11;
        tick();
        idle_in();
        if (p == 1) tick();
        chk("R3 R4 drivers on in data cycle", 32'(dq_oe), 32'd1);
        tick();
        chk(s ? "R4 drivers held" : "R3 drivers off", 32'(dq_oe), 32'(s));
        chk("R4 no valid after data", 32'(rvalid), 32'd0);
        if (s == 1) chk("R4 held word", 32'(rdata), 32'(model_mem[11]));
        tick();
        chk("R4 drivers off finally", 32'(dq_oe), 32'd0);
      end
    end
    dual_desel = 1'b0;

    // R8: asynchronous output enable.
    pipe_sel = 1'b0;
    cs = 1'b1; load = 1'b1; addr = 4'd12;
    tick();
    idle_in();
    oe = 1'b0;
    #1;
    chk("R8 oe low dq_oe", 32'(dq_oe), 32'd0);
    chk("R8 oe low rvalid", 32'(rvalid), 32'd0);
    chk("R8 oe low rdata", 32'(rdata), 32'd0);
    oe = 1'b1;
    #1;
    chk("R8 oe restored data", 32'(rdata), 32'(model_mem[12]));
    tick(); tick();

    // R10: linear then interleaved bursts from base 5, including the wrap.
    for (int m = 0; m < 2; m++) begin
      logic [3:0] seq [5];
      if (m == 0) seq = '{4'd5, 4'd6, 4'd7, 4'd4, 4'd5};
      else        seq = '{4'd5, 4'd4, 4'd7, 4'd6, 4'd5};
      burst_lin = (m == 0);
      cs = 1'b1; load = 1'b1; addr = 4'd5;
      for (int b = 0; b < 5; b++) begin
        tick();
        load = 1'b0; adv = 1'b1;
        chk(m == 0 ? "R10 linear beat" : "R10 interleaved beat", 32'(rdata), 32'(model_mem[seq[b]]));
      end
      idle_in();
      tick(); tick();
    end
    burst_lin = 1'b1;

    // R9: sleep gating, ignored commands, one skipped edge on wake.
    cs = 1'b1; load = 1'b1; addr = 4'd2;
    tick();
    idle_in();
    chk("R9 read before sleep", 32'(rvalid), 32'd1);
    sleep = 1'b1;
    #1;
    chk("R9 sleep dq_oe", 32'(dq_oe), 32'd0);
    chk("R9 sleep rvalid", 32'(rvalid), 32'd0);
    cs = 1'b1; load = 1'b1; addr = 4'd2; glb_wr = 1'b1; wdata = 18'h0BEEF;
    tick(); tick();
    sleep = 1'b0;
    tick();
    glb_wr = 1'b0;
    tick();
    idle_in();
    chk("R9 contents kept, commands ignored", 32'(rdata), 32'(model_mem[2]));
    chk("R9 second edge after wake accepted", 32'(rvalid), 32'd1);
    tick(); tick();

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule